// File: doc/BRIEF.md
# Matrix Keypad Scanner with Character Decoder

This block services a 4×4 key matrix wired with pulled-up column lines and row lines that it drives itself. While no key is pressed it holds every row low and watches the columns. The first column that drops to 0 starts a debounce wait. After that wait the block drives one row low at a time, lowest row first, to find which row and column the closed key sits on. It turns that position into an ASCII character and offers it on a valid/ready output. It then stays locked until every key has been let go, so one physical press yields exactly one character.

Column inputs pass through a two-stage synchronizer before the state machine uses them. A separate wake output is formed combinationally from the raw column lines, so a sleeping processor can be woken without a clock. The debounce time and the settle time after each row change are parameters counted in clock cycles. The defaults give 20 ms and 5 µs at 125 MHz.

Top module: `kpad_scanner`

## Requirements
- R1: After reset, and whenever no key is down, all four `row_drv` lines are 0 and `key_valid` is 0.
- R2: `wake` is 1 exactly when at least one `col_in` line is 0. It follows the inputs with no clock delay.
- R3: No character is offered until at least `DEBOUNCE_CYC` clock cycles after the column drop that started the press.
- R4: While locating a key, exactly one row line is 0. Rows are tried in ascending order, and each row is held for `SETTLE_CYC` cycles before the columns are judged. If closed keys sit on several rows, the lowest-numbered row wins.
- R5: Within the row that is found, the lowest-numbered column that reads 0 wins. The key index is row × 4 + column, where `row_drv[r]` is row r and `col_in[c]` is column c.
- R6: The index selects an 8-bit ASCII code from this table, one table row per matrix row, columns 0 to 3 left to right: row 0 "1 2 3 A", row 1 "4 5 6 B", row 2 "7 8 9 C", row 3 "* 0 # D".
- R7: While `key_valid` is 1 and `key_ready` is 0, `key_valid` stays 1 and `key_char` keeps its value, even if the key is released meanwhile. The cycle after `key_valid` and `key_ready` are both 1, `key_valid` is 0.
- R8: After a character is accepted, no further character is offered until every column reads 1 with all rows driven 0. A key held down, or a second key added while the first is held, produces nothing more.
- R9: If a scan of all four rows finds no column at 0, for example because the press ended during debounce, the block goes back to idle and offers nothing.
- R10: Contact bounce, meaning a key toggling open and closed for less than the debounce time before it settles closed, yields exactly one character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| col_in | input | 4 | Column lines from the matrix; 1 when open, 0 when a closed key meets a low row |
| row_drv | output | 4 | Row drive lines; 0 selects a row |
| wake | output | 1 | Combinational any-key-down flag |
| key_valid | output | 1 | A decoded character is on offer |
| key_char | output | 8 | ASCII code of the pressed key |
| key_ready | input | 1 | Consumer accepts the character this cycle |

## Verification
Two things can overlap in time: the consumer stalling the output, and the key being released, which the release lockout watches for. The bench provokes this by holding `key_ready` low, releasing the key while the character is on offer, and waiting many cycles. It then judges that the character stayed stable and valid through the release, was accepted exactly once, and that the block came back to idle with all rows low. A second overlap joins a held key with a newly added key while the lockout is active. The check is that the count of offered characters does not change until all keys are open.

// File: rtl/kpad_pkg.sv
package kpad_pkg;
    localparam int KP_ROWS = 4;
    localparam int KP_COLS = 4;
    localparam int KP_KEYS = KP_ROWS * KP_COLS;
    localparam int KP_CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BOUNCE,
        ST_LOCATE,
        ST_OFFER,
        ST_RELEASE
    } scan_st_e;
endpackage

// File: rtl/kpad_sync.sv
module kpad_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Open columns read 1, so the flops reset to 1.
    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stage_q[s] <= '1;
                else if (s == 0)
                    stage_q[s] <= d_in;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/kpad_lowfind.sv
module kpad_lowfind #(
    parameter int WIDTH = 4,
    localparam int IW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] lines,
    output logic             any_low,
    output logic [IW-1:0]    low_idx
);
    // Priority to the lowest-numbered line reading 0.
    always_comb begin
        any_low = 1'b0;
        low_idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (!lines[i]) begin
                any_low = 1'b1;
                low_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/kpad_charmap.sv
module kpad_charmap
    import kpad_pkg::*;
(
    input  logic [$clog2(KP_KEYS)-1:0] key_idx,
    output logic [KP_CHAR_W-1:0]       key_code
);
    always_comb begin
        case (key_idx)
            4'd0:    key_code = "1";
            4'd1:    key_code = "2";
            4'd2:    key_code = "3";
            4'd3:    key_code = "A";
            4'd4:    key_code = "4";
            4'd5:    key_code = "5";
            4'd6:    key_code = "6";
            4'd7:    key_code = "B";
            4'd8:    key_code = "7";
            4'd9:    key_code = "8";
            4'd10:   key_code = "9";
            4'd11:   key_code = "C";
            4'd12:   key_code = "*";
            4'd13:   key_code = "0";
            4'd14:   key_code = "#";
            default: key_code = "D";
        endcase
    end
endmodule

// File: rtl/kpad_scanner.sv
module kpad_scanner
    import kpad_pkg::*;
#(
    parameter int DEBOUNCE_CYC = 2_500_000,
    parameter int SETTLE_CYC   = 625,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [KP_COLS-1:0]   col_in,
    output logic [KP_ROWS-1:0]   row_drv,
    output logic                 wake,
    output logic                 key_valid,
    output logic [KP_CHAR_W-1:0] key_char,
    input  logic                 key_ready
);
    // SETTLE_CYC must exceed SYNC_STAGES so the judged sample reflects the new row.
    localparam int CNT_MAX = (DEBOUNCE_CYC > SETTLE_CYC) ? DEBOUNCE_CYC : SETTLE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int ROW_W   = $clog2(KP_ROWS);
    localparam int COL_W   = $clog2(KP_COLS);
    localparam int IDX_W   = $clog2(KP_KEYS);

    typedef struct packed {
        scan_st_e             st;
        logic [CNT_W-1:0]     cnt;
        logic [ROW_W-1:0]     row;
        logic [KP_CHAR_W-1:0] chr;
    } scan_regs_t;

    scan_regs_t regs_d, regs_q;

    logic [KP_COLS-1:0]   col_sync;
    logic                 col_any_low;
    logic [COL_W-1:0]     col_idx;
    logic [IDX_W-1:0]     key_idx;
    logic [KP_CHAR_W-1:0] map_code;

    kpad_sync #(.WIDTH(KP_COLS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (col_in),
        .d_out (col_sync)
    );

    kpad_lowfind #(.WIDTH(KP_COLS)) u_lowfind (
        .lines   (col_sync),
        .any_low (col_any_low),
        .low_idx (col_idx)
    );

    assign key_idx = IDX_W'(regs_q.row) * IDX_W'(KP_COLS) + IDX_W'(col_idx);

    kpad_charmap u_charmap (
        .key_idx  (key_idx),
        .key_code (map_code)
    );

    always_comb begin
        regs_d = regs_q;
        case (regs_q.st)
            ST_IDLE: begin
                if (col_any_low) begin
                    regs_d.st  = ST_BOUNCE;
                    regs_d.cnt = '0;
                end
            end
            ST_BOUNCE: begin
                if (regs_q.cnt == CNT_W'(DEBOUNCE_CYC - 1)) begin
                    regs_d.st  = ST_LOCATE;
                    regs_d.cnt = '0;
                    regs_d.row = '0;
                end else begin
                    regs_d.cnt = regs_q.cnt + 1'b1;
                end
            end
            ST_LOCATE: begin
                if (regs_q.cnt == CNT_W'(SETTLE_CYC - 1)) begin
                    regs_d.cnt = '0;
                    if (col_any_low) begin
                        regs_d.chr = map_code;
                        regs_d.st  = ST_OFFER;
                    end else if (regs_q.row == ROW_W'(KP_ROWS - 1)) begin
                        regs_d.st  = ST_IDLE;
                    end else begin
                        regs_d.row = regs_q.row + 1'b1;
                    end
                end else begin
                    regs_d.cnt = regs_q.cnt + 1'b1;
                end
            end
            ST_OFFER: begin
                if (key_ready)
                    regs_d.st = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (!col_any_low)
                    regs_d.st = ST_IDLE;
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.st  <= ST_IDLE;
            regs_q.cnt <= '0;
            regs_q.row <= '0;
            regs_q.chr <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        if (regs_q.st == ST_LOCATE || regs_q.st == ST_OFFER)
            row_drv = ~(KP_ROWS'(1) << regs_q.row);
        else
            row_drv = '0;
    end

    assign wake      = ~&col_in;
    assign key_valid = (regs_q.st == ST_OFFER);
    assign key_char  = regs_q.chr;
endmodule

// File: rtl/kpad_scanner_chk.sv
module kpad_scanner_chk
    import kpad_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [KP_COLS-1:0]   col_in,
    input logic [KP_ROWS-1:0]   row_drv,
    input logic                 wake,
    input logic                 key_valid,
    input logic [KP_CHAR_W-1:0] key_char,
    input logic                 key_ready
);
    // R7: a stalled offer keeps both flag and code
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && !key_ready |=> key_valid && $stable(key_char));

    // R7, R8: an accepted offer is withdrawn on the next cycle
    assert_single_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && key_ready |=> !key_valid);

    // R4: rows are either all low or exactly one low
    assert_row_pattern_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (row_drv == '0) || ($countones(~row_drv) == 1));

    // R4: an offer only appears right after a single-row probe
    assert_offer_from_probe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_valid) |-> $countones(~$past(row_drv)) == 1);

    // R2: the wake line reflects the column lines at each edge
    assert_wake_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wake == (col_in != '1));

    // R1: while nothing is offered and no row is probed, rows idle low
    assert_idle_rows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid && $countones(~row_drv) != 1 |-> row_drv == '0);
endmodule

bind kpad_scanner kpad_scanner_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .col_in    (col_in),
    .row_drv   (row_drv),
    .wake      (wake),
    .key_valid (key_valid),
    .key_char  (key_char),
    .key_ready (key_ready)
);

// File: tb/kpad_scanner_tb.sv
`timescale 1ns/1ps
module kpad_scanner_tb;
    localparam int DEB = 40;
    localparam int SET = 4;
    localparam int WAIT_LIMIT = 600;
    localparam logic [7:0] EXP_CHAR [16] = '{
        "1","2","3","A","4","5","6","B","7","8","9","C","*","0","#","D"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  col_in;
    logic [3:0]  row_drv;
    logic        wake;
    logic        key_valid;
    logic [7:0]  key_char;
    logic        key_ready = 1'b0;
    logic [15:0] keys_down = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int rises    = 0;
    int cyc      = 0;
    logic prev_v = 1'b0;

    always #4 clk = ~clk;

    kpad_scanner #(.DEBOUNCE_CYC(DEB), .SETTLE_CYC(SET)) u_dut (
        .clk(clk), .rst_n(rst_n), .col_in(col_in), .row_drv(row_drv),
        .wake(wake), .key_valid(key_valid), .key_char(key_char),
        .key_ready(key_ready)
    );

    // Matrix model: column c is 0 when a closed key on a low row touches it.
    always_comb begin
        for (int c = 0; c < 4; c++) begin
            col_in[c] = 1'b1;
            for (int r = 0; r < 4; r++)
                if (keys_down[r*4+c] && !row_drv[r]) col_in[c] = 1'b0;
        end
    end

    always @(posedge clk) begin
        prev_v <= key_valid;
        if (key_valid && !prev_v) rises <= rises + 1;
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: run hung, act=%0d exp=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic ncyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Waits for an offer; returns cycles spent, or -1 on timeout.
    task automatic wait_valid(output int spent);
        spent = -1;
        for (int i = 0; i < WAIT_LIMIT; i++) begin
            @(negedge clk);
            if (key_valid) begin
                spent = i + 1;
                break;
            end
        end
    endtask

    task automatic accept();
        key_ready = 1'b1;
        @(negedge clk);
        key_ready = 1'b0;
    endtask

    initial begin
        int spent;
        int base;
        ncyc(3);
        rst_n = 1'b1;
        ncyc(2);

        // R1 reset state
        chk(row_drv == 4'b0000, "R1 rows after reset", row_drv, 0);
        chk(!key_valid, "R1 valid after reset", key_valid, 0);
        // R2 no key, no wake
        chk(!wake, "R2 wake idle", wake, 0);

        // Vector walk: every key decodes to its character (R5, R6)
        for (int k = 0; k < 16; k++) begin
            keys_down = 16'(1) << k;
            #1;
            chk(wake, "R2 wake on press", wake, 1);
            wait_valid(spent);
            chk(spent >= DEB, "R3 debounce wait", spent, DEB);
            chk(key_char == EXP_CHAR[k], "R6 char map", key_char, EXP_CHAR[k]);
            accept();
            keys_down = '0;
            ncyc(10);
        end

        // R5 column priority within a row: keys 13 and 14 -> "0"
        keys_down = 16'h6000;
        wait_valid(spent);
        chk(key_char == "0", "R5 lowest column wins", key_char, "0");
        accept();
        keys_down = '0;
        ncyc(10);

        // R4 row priority: keys 5 and 8 -> "5"
        keys_down = 16'h0120;
        wait_valid(spent);
        chk(key_char == "5", "R4 lowest row wins", key_char, "5");
        accept();
        keys_down = '0;
        ncyc(10);

        // R7 stall while the key is released
        keys_down = 16'h0008;
        wait_valid(spent);
        keys_down = '0;
        ncyc(25);
        chk(key_valid, "R7 valid held under stall", key_valid, 1);
        chk(key_char == "A", "R7 char held under stall", key_char, "A");
        base = rises;
        accept();
        chk(!key_valid, "R7 valid drops after accept", key_valid, 0);
        ncyc(5);
        chk(row_drv == 4'b0000, "R1 rows back to idle", row_drv, 0);
        chk(rises == base, "R7 no extra offer", rises, base);

        // R8 held key plus added key during lockout
        keys_down = 16'h0001;
        wait_valid(spent);
        accept();
        base = rises;
        ncyc(3 * DEB);
        keys_down = 16'h0401;
        ncyc(3 * DEB);
        chk(rises == base, "R8 lockout while held", rises, base);
        chk(!key_valid, "R8 no offer while held", key_valid, 0);
        keys_down = '0;
        ncyc(10);
        keys_down = 16'h0800;
        wait_valid(spent);
        chk(key_char == "C", "R8 new press after release", key_char, "C");
        accept();
        keys_down = '0;
        ncyc(10);

        // R9 press vanishes during debounce
        base = rises;
        keys_down = 16'h0040;
        ncyc(8);
        keys_down = '0;
        ncyc(4 * DEB);
        chk(rises == base, "R9 no offer for vanished press", rises, base);
        chk(row_drv == 4'b0000, "R9 back to idle", row_drv, 0);

        // R10 bouncing contact then settled
        base = rises;
        for (int b = 0; b < 5; b++) begin
            keys_down = 16'h0200;
            ncyc(3);
            keys_down = '0;
            ncyc(3);
        end
        keys_down = 16'h0200;
        wait_valid(spent);
        chk(key_char == "8", "R10 char after bounce", key_char, "8");
        accept();
        keys_down = '0;
        ncyc(4 * DEB);
        chk(rises == base + 1, "R10 exactly one offer", rises, base + 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule